// File: doc/BRIEF.md
# Split-Word Interrupt Routing Register File

This block sits between a 32-bit word-aligned register bus and a wide interrupt state of 51 sources. An external trigger detector supplies the pending vector and the per-source sense and dual-edge configuration. The block holds the enable vector, the routing select vector and the event-polarity vector. It drives two level outputs. `irq_o` is the normal interrupt and `fiq_o` is the fast interrupt. Each source reaches one of them, chosen by its select bit.

Every 51-bit quantity is seen as two 32-bit words. The low word carries sources 31 to 0. The high word carries sources 50 to 32 in its bits 18:0 and reads zero above them. In the main window, starting at byte offset 0x80, address bit 2 picks the word. Below 0x80 a compact alias window reaches only the low words.

Enable uses separate set and clear addresses, so no read-modify-write is needed. Select is written one word at a time. Only the four top sources may have their event polarity changed. A write to the edge-clear address emits a one-cycle clear mask toward the detector. Software interrupt addresses accept writes and do nothing with them.

Top module: `vic_regfile`

## Requirements
- R1: After synchronous reset, enable and select are all zero. `irq_o`, `fiq_o` and `edge_clr_o` are low. `event_o` equals the parameter `EVT_RST`.
- R2: In the main window (byte address 0x80 and above), address bit 2 set selects the high word. High-word writes use data bits 18:0 only. High-word reads return sources 50:32 zero-extended.
- R3: The following views can be read. Normal status is pending AND enable AND NOT select, at 0x80. Fast status is pending AND enable AND select, at 0x88. Pending is at 0x90. Edge status is pending AND NOT sense, at 0xE0. Sense is at 0xC0 and dual-edge at 0xC8. Each view adds 4 to reach its high word.
- R4: `irq_o` is the OR of all normal status bits and `fiq_o` is the OR of all fast status bits. Both are registered, so they reflect the state one clock edge after it changes.
- R5: Writing 0xA0 (high word 0xA4) ORs the data into enable. Writing 0xA8 (high word 0xAC) clears the enable bits written as one. Reading 0xA0 or 0xA4 returns enable.
- R6: Writing select at 0x98 or 0x9C replaces only the addressed word and keeps the other word.
- R7: The event vector can be read at 0xD0 and 0xD4. Only a write to 0xD4 changes it, and only for sources 50 to 47, taken from data bits 18:15. Writes to 0xD0 or the alias 0x2C are ignored.
- R8: A write to edge clear (0xD8, 0xDC, alias 0x38) drives `edge_clr_o` for exactly one cycle, starting one edge after the write. The mask holds the written bits placed in the addressed word, with level-sensed sources (sense bit 1) removed. At all other times `edge_clr_o` is zero.
- R9: The alias window reaches the low word at these offsets: 0x00 normal status, 0x04 fast status, 0x08 pending, 0x0C select, 0x10 enable set, 0x14 enable clear, 0x24 sense, 0x28 dual-edge.
- R10: The following reads return zero: enable clear, software set and clear, edge clear, and any unmapped offset. Writes to status, pending or software addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| raw_i | input | 51 | Pending vector from the detector |
| sense_i | input | 51 | Per-source sense, 1 = level |
| dual_i | input | 51 | Per-source dual-edge configuration |
| event_o | output | 51 | Event polarity vector to the detector |
| edge_clr_o | output | 51 | One-cycle edge-clear mask |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A change of the pending input and a bus write to enable can land on the same clock edge. The bench raises a new pending source in the very cycle that enables it. It then expects `irq_o` to stay low at that edge, because the output was computed from the old enable. At the following edge `irq_o` must be high. A second coincidence is an edge-clear write that names a level-sensed source together with an edge-sensed one. It is judged by requiring exactly the edge-sensed bit in the single-cycle mask.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        RG_NSTAT, RG_FSTAT, RG_PEND, RG_SEL, RG_ENSET, RG_ENCLR,
        RG_SWSET, RG_SWCLR, RG_SENSE, RG_DUAL, RG_EVENT, RG_EDGECLR,
        RG_EDGESTAT, RG_NONE
    } reg_e;

    typedef struct packed {
        reg_e id;
        logic hi;
    } dec_t;

    // Decode a byte address into a register identity and a word half.
    function automatic dec_t vic_decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        logic [ADDR_W-1:0] k;
        if (a < 8'h80) begin
            d.hi = 1'b0;
            k    = {a[ADDR_W-1:2], 2'b00};
        end else begin
            d.hi = a[2];
            k    = {a[ADDR_W-1:3], 3'b000};
        end
        case (k)
            8'h80, 8'h00: d.id = RG_NSTAT;
            8'h88, 8'h04: d.id = RG_FSTAT;
            8'h90, 8'h08: d.id = RG_PEND;
            8'h98, 8'h0C: d.id = RG_SEL;
            8'hA0, 8'h10: d.id = RG_ENSET;
            8'hA8, 8'h14: d.id = RG_ENCLR;
            8'hB0, 8'h18: d.id = RG_SWSET;
            8'hB8, 8'h1C: d.id = RG_SWCLR;
            8'hC0, 8'h24: d.id = RG_SENSE;
            8'hC8, 8'h28: d.id = RG_DUAL;
            8'hD0, 8'h2C: d.id = RG_EVENT;
            8'hD8, 8'h38: d.id = RG_EDGECLR;
            8'hE0:        d.id = RG_EDGESTAT;
            default:      d.id = RG_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter int NSRC = 51,
    parameter int EVT_LO = 47,
    parameter logic [NSRC-1:0] EVT_RST = 51'h5F07FFF8FFFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  dec_t            dec,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NSRC-1:0] sense,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] sel_q,
    output logic [NSRC-1:0] evt_q,
    output logic [NSRC-1:0] clr_q
);
    localparam int HI_W = NSRC - WORD_W;
    localparam logic [NSRC-1:0] EVT_MASK = {NSRC{1'b1}} << EVT_LO;

    logic [NSRC-1:0] wpos, hmask;

    always_comb begin
        if (dec.hi) begin
            wpos  = {wdata[HI_W-1:0], {WORD_W{1'b0}}};
            hmask = {{HI_W{1'b1}}, {WORD_W{1'b0}}};
        end else begin
            wpos  = {{HI_W{1'b0}}, wdata};
            hmask = {{HI_W{1'b0}}, {WORD_W{1'b1}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
            evt_q <= EVT_RST;
            clr_q <= '0;
        end else begin
            clr_q <= '0;
            if (wr_en) begin
                case (dec.id)
                    RG_ENSET:   en_q  <= en_q | wpos;
                    RG_ENCLR:   en_q  <= en_q & ~wpos;
                    RG_SEL:     sel_q <= (sel_q & ~hmask) | wpos;
                    RG_EVENT:   if (dec.hi) evt_q <= (evt_q & ~EVT_MASK) | (wpos & EVT_MASK);
                    RG_EDGECLR: clr_q <= wpos & ~sense;
                    default: ;
                endcase
            end
        end
    end

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.id == RG_ENSET) |=> ((en_q & $past(en_q)) == $past(en_q)));

    // R6
    sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.id == RG_SEL && !dec.hi) |=> (sel_q[NSRC-1:WORD_W] == $past(sel_q[NSRC-1:WORD_W])));

    // R7
    evt_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(evt_q[EVT_LO-1:0]));

    // R8
    clr_level_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((clr_q & $past(sense)) == '0));

    // R8
    clr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dec.id == RG_EDGECLR) |=> (clr_q == '0));

endmodule

// File: rtl/vic_read_mux.sv
module vic_read_mux
    import vic_pkg::*;
#(
    parameter int NSRC = 51
) (
    input  dec_t              dec,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   sense,
    input  logic [NSRC-1:0]   dual,
    input  logic [NSRC-1:0]   en,
    input  logic [NSRC-1:0]   sel,
    input  logic [NSRC-1:0]   evt,
    output logic [WORD_W-1:0] rdata
);
    localparam int HI_W = NSRC - WORD_W;

    logic [NSRC-1:0] view;

    always_comb begin
        case (dec.id)
            RG_NSTAT:    view = raw & en & ~sel;
            RG_FSTAT:    view = raw & en & sel;
            RG_PEND:     view = raw;
            RG_SEL:      view = sel;
            RG_ENSET:    view = en;
            RG_SENSE:    view = sense;
            RG_DUAL:     view = dual;
            RG_EVENT:    view = evt;
            RG_EDGESTAT: view = raw & ~sense;
            default:     view = '0;
        endcase
        if (dec.hi)
            rdata = {{(WORD_W-HI_W){1'b0}}, view[NSRC-1:WORD_W]};
        else
            rdata = view[WORD_W-1:0];
    end

endmodule

// File: rtl/vic_route.sv
module vic_route #(
    parameter int NSRC = 51
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] sel,
    output logic            irq_q,
    output logic            fiq_q
);
    logic [NSRC-1:0] live;

    assign live = raw & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |(live & ~sel);
            fiq_q <= |(live & sel);
        end
    end

    // R4
    route_split_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel) == '0) |-> !fiq_q);

endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int NSRC = 51,
    parameter int EVT_LO = 47,
    parameter logic [NSRC-1:0] EVT_RST = 51'h5F07FFF8FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [NSRC-1:0]   sense_i,
    input  logic [NSRC-1:0]   dual_i,
    output logic [NSRC-1:0]   event_o,
    output logic [NSRC-1:0]   edge_clr_o,
    output logic              irq_o,
    output logic              fiq_o
);
    dec_t            dec;
    logic [NSRC-1:0] en_q, sel_q;

    assign dec = vic_decode(bus_addr);

    vic_cfg_regs #(.NSRC(NSRC), .EVT_LO(EVT_LO), .EVT_RST(EVT_RST)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(bus_we), .dec(dec), .wdata(bus_wdata),
        .sense(sense_i), .en_q(en_q), .sel_q(sel_q), .evt_q(event_o),
        .clr_q(edge_clr_o)
    );

    vic_read_mux #(.NSRC(NSRC)) u_rd (
        .dec(dec), .raw(raw_i), .sense(sense_i), .dual(dual_i),
        .en(en_q), .sel(sel_q), .evt(event_o), .rdata(bus_rdata)
    );

    vic_route #(.NSRC(NSRC)) u_route (
        .clk(clk), .rst(rst), .raw(raw_i), .en(en_q), .sel(sel_q),
        .irq_q(irq_o), .fiq_q(fiq_o)
    );

    // R4
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |=> (!irq_o && !fiq_o));

endmodule

// File: tb/test_vic_regfile.sv
module test_vic_regfile;
    localparam int PERIOD = 10;
    localparam int NSRC = 51;

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h80, 32'h0, 4'd3},        // R3 nothing enabled
        '{1'b1, 8'hA0, 32'hF0, 4'd5},
        '{1'b1, 8'hA4, 32'hFFFFFFFF, 4'd2},
        '{1'b0, 8'hA0, 32'hF0, 4'd5},       // R5
        '{1'b0, 8'hA4, 32'h7FFFF, 4'd2},    // R2 masked high word
        '{1'b1, 8'hA8, 32'h30, 4'd5},
        '{1'b0, 8'hA0, 32'hC0, 4'd5},       // R5 clear
        '{1'b0, 8'h80, 32'hC0, 4'd3},
        '{1'b1, 8'h98, 32'h80, 4'd6},
        '{1'b1, 8'h9C, 32'h1, 4'd6},
        '{1'b0, 8'h98, 32'h80, 4'd6},
        '{1'b0, 8'h9C, 32'h1, 4'd6},
        '{1'b1, 8'h98, 32'h40, 4'd6},
        '{1'b0, 8'h9C, 32'h1, 4'd6},        // R6 other half kept
        '{1'b0, 8'h98, 32'h40, 4'd6},
        '{1'b0, 8'h80, 32'h80, 4'd3},
        '{1'b0, 8'h88, 32'h40, 4'd3},
        '{1'b0, 8'h84, 32'h40002, 4'd3},
        '{1'b0, 8'h8C, 32'h1, 4'd3},
        '{1'b0, 8'h90, 32'hFF, 4'd3},
        '{1'b0, 8'h94, 32'h40003, 4'd2},
        '{1'b0, 8'hE0, 32'hF0, 4'd3},
        '{1'b0, 8'hE4, 32'h40002, 4'd3},
        '{1'b0, 8'hC0, 32'hF, 4'd3},
        '{1'b0, 8'hC4, 32'h1, 4'd2},
        '{1'b0, 8'hC8, 32'h12345678, 4'd3},
        '{1'b0, 8'hCC, 32'hF00, 4'd3},
        '{1'b0, 8'hD4, 32'h5F07, 4'd7},     // R7 reset value
        '{1'b0, 8'hD0, 32'hFFF8FFFF, 4'd7},
        '{1'b1, 8'hD4, 32'hFFFFFFFF, 4'd7},
        '{1'b0, 8'hD4, 32'h7DF07, 4'd7},
        '{1'b1, 8'hD4, 32'h0, 4'd7},
        '{1'b0, 8'hD4, 32'h5F07, 4'd7},
        '{1'b1, 8'hD0, 32'h0, 4'd7},
        '{1'b0, 8'hD0, 32'hFFF8FFFF, 4'd7},
        '{1'b1, 8'h2C, 32'h0, 4'd7},
        '{1'b0, 8'h2C, 32'hFFF8FFFF, 4'd7},
        '{1'b0, 8'h0C, 32'h40, 4'd9},       // R9 alias
        '{1'b0, 8'h10, 32'hC0, 4'd9},
        '{1'b1, 8'h14, 32'h80, 4'd9},
        '{1'b0, 8'h10, 32'h40, 4'd9},
        '{1'b1, 8'h10, 32'h100, 4'd9},
        '{1'b0, 8'h10, 32'h140, 4'd9},
        '{1'b0, 8'h00, 32'h0, 4'd9},
        '{1'b0, 8'h04, 32'h40, 4'd9},
        '{1'b0, 8'h08, 32'hFF, 4'd9},
        '{1'b0, 8'h24, 32'hF, 4'd9},
        '{1'b0, 8'h28, 32'h12345678, 4'd9},
        '{1'b0, 8'hA8, 32'h0, 4'd10},       // R10 zero reads
        '{1'b0, 8'hB8, 32'h0, 4'd10},
        '{1'b0, 8'hD8, 32'h0, 4'd10},
        '{1'b0, 8'hB0, 32'h0, 4'd10},
        '{1'b0, 8'h14, 32'h0, 4'd10},
        '{1'b0, 8'hF0, 32'h0, 4'd10},
        '{1'b0, 8'h30, 32'h0, 4'd10},
        '{1'b0, 8'hDC, 32'h0, 4'd10},
        '{1'b1, 8'h80, 32'hFFFFFFFF, 4'd10},
        '{1'b1, 8'hB0, 32'hFFFFFFFF, 4'd10},
        '{1'b1, 8'h90, 32'h0, 4'd10},
        '{1'b0, 8'hA0, 32'h140, 4'd10},
        '{1'b0, 8'hB0, 32'h0, 4'd10},
        '{1'b0, 8'h98, 32'h40, 4'd10},
        '{1'b0, 8'hA4, 32'h7FFFF, 4'd10}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] raw_i = {19'h40003, 32'h000000FF};
    logic [NSRC-1:0] sense_i = {19'h00001, 32'h0000000F};
    logic [NSRC-1:0] dual_i = {19'h00F00, 32'h12345678};
    logic [NSRC-1:0] event_o, edge_clr_o;
    logic            irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    vic_regfile i_vic_regfile (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_i(raw_i),
        .sense_i(sense_i), .dual_i(dual_i), .event_o(event_o),
        .edge_clr_o(edge_clr_o), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", 64'(irq_o), 64'd0);
        chk("R1 fiq", 64'(fiq_o), 64'd0);
        chk("R1 edge_clr", 64'(edge_clr_o), 64'd0);
        chk("R1 event", 64'(event_o), 64'h5F07FFF8FFFF);
        rd("R1 select", 8'h98, 32'h0);
        rd("R1 enable", 8'hA4, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) begin
                wr(TBL[i].a, TBL[i].d);
            end else begin
                rd($sformatf("R%0d table[%0d] addr %h", TBL[i].r, i, TBL[i].a), TBL[i].a, TBL[i].d);
                @(negedge clk);
            end
        end

        // R4 both outputs active from table state
        chk("R4 irq on", 64'(irq_o), 64'd1);
        chk("R4 fiq on", 64'(fiq_o), 64'd1);
        wr(8'hAC, 32'hFFFFFFFF);
        wr(8'hA8, 32'hFFFFFFFF);
        chk("R4 fiq one edge late", 64'(fiq_o), 64'd1);
        chk("R4 irq after high clear", 64'(irq_o), 64'd0);
        @(negedge clk);
        chk("R4 fiq cleared", 64'(fiq_o), 64'd0);
        wr(8'hA4, 32'h2);
        chk("R4 irq old state", 64'(irq_o), 64'd0);
        @(negedge clk);
        chk("R4 irq raised", 64'(irq_o), 64'd1);
        chk("R4 fiq stays low", 64'(fiq_o), 64'd0);
        raw_i[33] = 1'b0;
        @(negedge clk);
        chk("R4 irq follows pending", 64'(irq_o), 64'd0);

        // R4 coincidence: new pending source and its enable on one edge
        raw_i[34] = 1'b1;
        wr(8'hA4, 32'h4);
        chk("R4 coincident old", 64'(irq_o), 64'd0);
        @(negedge clk);
        chk("R4 coincident new", 64'(irq_o), 64'd1);

        // R8 edge clear pulses
        wr(8'hDC, 32'h3);
        chk("R8 high pulse", 64'(edge_clr_o), 64'(51'h1 << 33));
        @(negedge clk);
        chk("R8 pulse ends", 64'(edge_clr_o), 64'd0);
        wr(8'h38, 32'hFF);
        chk("R8 alias low pulse", 64'(edge_clr_o), 64'hF0);
        @(negedge clk);
        chk("R8 alias pulse ends", 64'(edge_clr_o), 64'd0);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd("R1 enable after reset", 8'hA4, 32'h0);
        rd("R1 select after reset", 8'h9C, 32'h0);
        chk("R1 irq after reset", 64'(irq_o), 64'd0);
        finish_run();
    end

endmodule